// File: doc/BRIEF.md
# Debug-Aware Free-Running Timer Counter

This block is a 16-bit up-counter that runs on its own and has a selectable clock. The clock is either the bus clock divided by a power of two from 1 to 64, or rising edges on an external timer pin. Before the pin is used, it passes through a two-flop synchroniser and an edge detector. When the counter wraps from its all-ones value to zero, it sets an overflow flag. It can also raise an interrupt request if software has enabled that.

Two halt inputs freeze the counter and the bus-clock divider without disturbing any stored state. One is a low-power stop input and the other is a debug break input. While break is active, software can inspect the block freely. A break-clear-enable control decides whether register accesses during break may clear the overflow flag.

The flag is cleared in two steps. Software first reads the status register while the flag is set, which arms the clear. It then writes 0 to the flag bit. An arm made before a break survives the break, so the clear can be finished once the break ends.

Top module: `dbg_timer`

## Requirements
- R1: After reset, the counter reads 0, the status register reads 0x00, `irq_o` is 0 and `dir_ovr_o` is 0.
- R2: With select codes 0 to 6 (bits 2:0 of the status register), the counter advances by exactly M/2^code over M unhalted bus cycles when M is a multiple of 64.
- R3: With select code 7, the counter advances once per rising edge of `ext_clk_i` and not on bus cycles, and `dir_ovr_o` is 1. With any other code, `dir_ovr_o` is 0.
- R4: While `stop_i` is 1, the counter and the divider hold. Counting resumes from the held value when `stop_i` returns to 0.
- R5: While `brk_i` is 1, the counter holds.
- R6: A wrap from 0xFFFF to 0x0000 sets the overflow flag (status bit 7). `irq_o` equals flag AND enable, where the enable is status bit 6.
- R7: The flag is cleared only when a status read (address 0) that sees the flag set is followed by a status write with bit 7 at 0. A write without that prior read leaves the flag set. A write with bit 7 at 1 leaves the flag set and keeps the clear armed.
- R8: With `brk_i` at 1 and `bclr_en_i` at 0, reads and writes do not change the flag and do not arm a clear. An arm made before the break still lets a write after the break clear the flag.
- R9: With `brk_i` at 1 and `bclr_en_i` at 1, the two-step clear works, and the flag stays 0 after the break ends.
- R10: The register map is as follows. Address 0 is status: bit 7 flag, bit 6 interrupt enable, bits 2:0 select, other bits read 0. Address 1 holds the counter high byte, address 2 holds the low byte, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk_i | input | 1 | External timer clock pin, asynchronous |
| stop_i | input | 1 | Low-power stop: freezes counter and divider |
| brk_i | input | 1 | Debug break state: freezes counter, gates flag clearing |
| bclr_en_i | input | 1 | Break-clear-enable: lets accesses clear the flag during break |
| addr_i | input | 2 | Register address |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Overflow interrupt request |
| dir_ovr_o | output | 1 | Forces the timer pin to input while the external clock is selected |

## Verification
The counting function is exercised with every bus-divider code over windows of random length that are multiples of 64 cycles. An error in the mask or the divider shows up as a count that is off by a power-of-two factor. External-clock mode is driven with pin pulses of four bus cycles and also with a static pin. Together these separate real edge counting from bus-clock leakage. Two full wraps from a known count place the flag-setting edge exactly, and then the clear sequence is run in four orders: without arming, arming before a break, arming inside a protected break, and clearing inside an unprotected break. Each order gives a different flag value under a wrong gating rule.

// File: rtl/dbg_timer_pkg.sv
package dbg_timer_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned PSEL_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_CNTH = 2'd1,
    REG_CNTL = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;

  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned IE_BIT   = 6;

  localparam logic [PSEL_W-1:0] PSEL_EXT = '1;

endpackage

// File: rtl/dbg_timer_tick.sv
module dbg_timer_tick
  import dbg_timer_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              ext_clk_i,
  output logic              tick_o
);

  localparam int unsigned DIV_W = (1 << PSEL_W) - 2;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [SYNC_N-1:0] sync_q;
  logic              hist_q;
  logic              ext_edge;
  logic              bus_tick;

  function automatic logic [DIV_W-1:0] low_mask(input logic [PSEL_W-1:0] code);
    logic [DIV_W-1:0] m;
    m = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(code)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // synchroniser stages
  for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= ext_clk_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= sync_q[SYNC_N-1];
  end

  assign ext_edge = sync_q[SYNC_N-1] & ~hist_q;

  // bus-clock divider, held while halted
  always_comb begin
    div_d = div_q;
    if (run_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign bus_tick = &(div_q | ~low_mask(psel_i));

  always_comb begin
    if (psel_i == PSEL_EXT) tick_o = run_i & ext_edge;
    else                    tick_o = run_i & bus_tick;
  end

endmodule

// File: rtl/dbg_timer_count.sv
module dbg_timer_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & (&cnt_q);

endmodule

// File: rtl/dbg_timer_flag.sv
module dbg_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wr_flag_bit_i,
  input  logic brk_i,
  input  logic bclr_en_i,
  output logic flag_o
);

  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic access_ok;
  logic clear_hit;

  assign access_ok = ~brk_i | bclr_en_i;
  assign clear_hit = access_ok & wr_stat_i & arm_q & ~wr_flag_bit_i;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (set_i) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (clear_hit) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (access_ok && rd_stat_i && flag_q) begin
      arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/dbg_timer.sv
module dbg_timer
  import dbg_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              stop_i,
  input  logic              brk_i,
  input  logic              bclr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              dir_ovr_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic              run;
  logic              cnt_tick;
  logic              cnt_wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_flag;
  logic              ovf_ie_q, ovf_ie_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              wr_stat, rd_stat;
  logic              unused_wr;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign run     = ~stop_i & ~brk_i;
  assign wr_stat = wr_en_i & (addr_i == REG_STAT);
  assign rd_stat = rd_en_i & (addr_i == REG_STAT);

  always_comb begin
    ovf_ie_d = ovf_ie_q;
    psel_d   = psel_q;
    if (wr_stat) begin
      ovf_ie_d = wr_data_i[IE_BIT];
      psel_d   = wr_data_i[PSEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovf_ie_q <= 1'b0;
      psel_q   <= '0;
    end else begin
      ovf_ie_q <= ovf_ie_d;
      psel_q   <= psel_d;
    end
  end

  assign unused_wr = ^wr_data_i[5:3];

  dbg_timer_tick #(.SYNC_N(2)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .run_i     (run),
    .psel_i    (psel_q),
    .ext_clk_i (ext_clk_i),
    .tick_o    (cnt_tick)
  );

  dbg_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .tick_i (cnt_tick),
    .cnt_o  (cnt_q),
    .wrap_o (cnt_wrap)
  );

  dbg_timer_flag u_flag (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_s),
    .set_i         (cnt_wrap),
    .rd_stat_i     (rd_stat),
    .wr_stat_i     (wr_stat),
    .wr_flag_bit_i (wr_data_i[FLAG_BIT]),
    .brk_i         (brk_i),
    .bclr_en_i     (bclr_en_i),
    .flag_o        (ovf_flag)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      REG_STAT: begin
        rd_data_o[FLAG_BIT]     = ovf_flag;
        rd_data_o[IE_BIT]       = ovf_ie_q;
        rd_data_o[PSEL_W-1:0]   = psel_q;
      end
      REG_CNTH: rd_data_o = cnt_q[CNT_W-1:DATA_W];
      REG_CNTL: rd_data_o = cnt_q[DATA_W-1:0];
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o     = ovf_flag & ovf_ie_q;
  assign dir_ovr_o = (psel_q == PSEL_EXT);

endmodule

// File: rtl/dbg_timer_chk.sv
module dbg_timer_chk
  import dbg_timer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic              stop_i,
  input logic              brk_i,
  input logic              bclr_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [15:0]       cnt,
  input logic              tick,
  input logic              flag,
  input logic              ie,
  input logic              irq,
  input logic              dir_ovr
);

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1)); // R2

  AST_EXT_DIR_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == REG_STAT && wr_data_i[2:0] == 3'b111) |=> dir_ovr); // R3

  AST_STOP_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_n)
    stop_i |=> $stable(cnt)); // R4

  AST_BREAK_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_n)
    brk_i |=> $stable(cnt)); // R5

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick && cnt == 16'hFFFF) |=> flag); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> (flag && ie)); // R6

  AST_BREAK_PROTECTS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    (brk_i && !bclr_en_i) |=> $stable(flag)); // R8

endmodule

bind dbg_timer dbg_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_s),
  .stop_i    (stop_i),
  .brk_i     (brk_i),
  .bclr_en_i (bclr_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .cnt       (cnt_q),
  .tick      (cnt_tick),
  .flag      (ovf_flag),
  .ie        (ovf_ie_q),
  .irq       (irq_o),
  .dir_ovr   (dir_ovr_o)
);

// File: tb/dbg_timer_bench.sv
module dbg_timer_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       ext_clk_i;
  logic       stop_i;
  logic       brk_i;
  logic       bclr_en_i;
  logic [1:0] addr_i;
  logic       rd_en_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic       irq_o;
  logic       dir_ovr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dbg_timer u_dbg_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_clk_i),
    .stop_i    (stop_i),
    .brk_i     (brk_i),
    .bclr_en_i (bclr_en_i),
    .addr_i    (addr_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .dir_ovr_o (dir_ovr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i  = a;
    rd_en_i = 1'b1;
    #1 d = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i    = a;
    wr_data_i = d;
    wr_en_i   = 1'b1;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic rd_cnt(output int c);
    logic [7:0] h, l;
    rd(2'd1, h);
    rd(2'd2, l);
    c = {h, l};
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk_i);
    stop_i = 1'b0;
    repeat (n) @(negedge clk_i);
    stop_i = 1'b1;
  endtask

  function automatic int expect_delta(input int m, input int code);
    return m >> code;
  endfunction

  function automatic logic [7:0] stat_val(input bit f, input bit ie, input int code);
    return {f, ie, 3'b000, 3'(code)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int c0, c1, code, m;
    void'($urandom(32'h5EED_1234));
    rst_ni = 1'b0; ext_clk_i = 1'b0; stop_i = 1'b1; brk_i = 1'b0;
    bclr_en_i = 1'b0; addr_i = '0; rd_en_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 reset state
    rd(2'd0, d);  chk(d == 8'h00, "R1 status", d, 0);
    rd_cnt(c0);   chk(c0 == 0, "R1 count", c0, 0);
    chk(irq_o == 1'b0 && dir_ovr_o == 1'b0, "R1 irq/dir", {irq_o, dir_ovr_o}, 0);
    // R10 reserved address
    rd(2'd3, d);  chk(d == 8'h00, "R10 reserved", d, 0);

    // R2 directed extremes then random codes
    for (int i = 0; i < 8; i++) begin
      code = (i == 0) ? 0 : (i == 1) ? 6 : $urandom_range(0, 6);
      m    = 64 * $urandom_range(1, 4);
      wr(2'd0, stat_val(0, 0, code));
      rd(2'd0, d); chk(d == stat_val(0, 0, code), "R10 status map", d, stat_val(0, 0, code));
      rd_cnt(c0);
      run_cycles(m);
      rd_cnt(c1);
      chk(c1 == ((c0 + expect_delta(m, code)) & 16'hFFFF), "R2 divide", c1,
          (c0 + expect_delta(m, code)) & 16'hFFFF);
    end

    // R4 stop hold
    wr(2'd0, stat_val(0, 0, 0));
    rd_cnt(c0);
    repeat (30) @(negedge clk_i);
    rd_cnt(c1); chk(c1 == c0, "R4 stop hold", c1, c0);

    // R5 break hold, then resume
    @(negedge clk_i); brk_i = 1'b1; stop_i = 1'b0;
    repeat (25) @(negedge clk_i);
    stop_i = 1'b1; brk_i = 1'b0;
    rd_cnt(c1); chk(c1 == c0, "R5 break hold", c1, c0);
    run_cycles(10);
    rd_cnt(c1); chk(c1 == ((c0 + 10) & 16'hFFFF), "R4 resume", c1, (c0 + 10) & 16'hFFFF);

    // R3 external clock
    wr(2'd0, stat_val(0, 0, 7));
    chk(dir_ovr_o == 1'b1, "R3 dir override", dir_ovr_o, 1);
    rd_cnt(c0);
    m = $urandom_range(5, 20);
    @(negedge clk_i); stop_i = 1'b0;
    for (int i = 0; i < m; i++) begin
      ext_clk_i = 1'b1; repeat (2) @(negedge clk_i);
      ext_clk_i = 1'b0; repeat (2) @(negedge clk_i);
    end
    repeat (6) @(negedge clk_i);
    stop_i = 1'b1;
    rd_cnt(c1); chk(c1 == ((c0 + m) & 16'hFFFF), "R3 edge count", c1, (c0 + m) & 16'hFFFF);
    run_cycles(40);
    rd_cnt(c0); chk(c0 == c1, "R3 no bus count", c0, c1);
    wr(2'd0, stat_val(0, 1, 0));
    chk(dir_ovr_o == 1'b0, "R3 dir released", dir_ovr_o, 0);

    // R6 first wrap
    rd_cnt(c0);
    run_cycles(65535 - c0);
    rd_cnt(c1); chk(c1 == 16'hFFFF, "R6 pre-wrap count", c1, 16'hFFFF);
    chk(irq_o == 1'b0, "R6 no early irq", irq_o, 0);
    run_cycles(1);
    rd_cnt(c1); chk(c1 == 0, "R6 wrapped count", c1, 0);
    chk(irq_o == 1'b1, "R6 irq", irq_o, 1);

    // R7 write without arming, then arm and write 1
    wr(2'd0, stat_val(0, 1, 0));
    chk(irq_o == 1'b1, "R7 unarmed write", irq_o, 1);
    rd(2'd0, d); chk(d == stat_val(1, 1, 0), "R7 status read", d, stat_val(1, 1, 0));
    wr(2'd0, stat_val(1, 1, 0));
    chk(irq_o == 1'b1, "R7 write one", irq_o, 1);

    // R8 armed before break: protected during break, completes after
    @(negedge clk_i); brk_i = 1'b1;
    wr(2'd0, stat_val(0, 1, 0));
    chk(irq_o == 1'b1, "R8 break protect", irq_o, 1);
    @(negedge clk_i); brk_i = 1'b0;
    wr(2'd0, stat_val(0, 1, 0));
    rd(2'd0, d); chk(d == stat_val(0, 1, 0), "R7 two-step clear", d, stat_val(0, 1, 0));

    // second wrap
    rd_cnt(c0);
    run_cycles(65536 - c0);
    chk(irq_o == 1'b1, "R6 second wrap", irq_o, 1);

    // R8 read+write inside protected break do nothing, and no arm survives
    @(negedge clk_i); brk_i = 1'b1;
    rd(2'd0, d);
    wr(2'd0, stat_val(0, 1, 0));
    chk(irq_o == 1'b1, "R8 in-break clear blocked", irq_o, 1);
    @(negedge clk_i); brk_i = 1'b0;
    wr(2'd0, stat_val(0, 1, 0));
    chk(irq_o == 1'b1, "R8 no arm in break", irq_o, 1);

    // R9 clear enabled during break
    @(negedge clk_i); brk_i = 1'b1; bclr_en_i = 1'b1;
    rd(2'd0, d);
    wr(2'd0, stat_val(0, 1, 0));
    rd(2'd0, d); chk(d[7] == 1'b0, "R9 cleared in break", d[7], 0);
    @(negedge clk_i); brk_i = 1'b0; bclr_en_i = 1'b0;
    rd(2'd0, d); chk(d == stat_val(0, 1, 0), "R9 stays cleared", d, stat_val(0, 1, 0));
    chk(irq_o == 1'b0, "R9 irq low", irq_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule